// File: doc/BRIEF.md
# Emulator External Memory Bus Decoder

This block sits between the CPU core of an 8-bit microcontroller emulator and its external memory socket. The emulator has no on-chip program ROM, so program memory lives in an external EPROM on a non-multiplexed bus. The bus has 13 address lines and 8 data lines. For every CPU bus cycle the block works out which region of the 8 KiB map the address falls in. From that it produces three things:

- an active-low output enable for external memory;
- an active-low status that shows the direction of data flow;
- the steering of the external data bus, and of the data handed back to the CPU.

The map has four kinds of space:

- a 32-byte I/O page at the bottom, with ten unused holes in it;
- a 128-byte external window;
- a 96-byte internal RAM, whose upper 64 bytes are the stack;
- everything from page one upward, which is external.

When the CPU reads internal I/O or RAM, the block drives the internal read data onto the external data bus, so that a logic analyser on the socket sees every read. Peripherals and RAM stay outside this block. Each is reached through a registered select output and returns data through one shared read-data input.

All control outputs come from flops that update on the rising clock edge. They therefore change once per cycle and never glitch inside a cycle. The data returned to the CPU is a mux driven by those flops, so an EPROM byte is taken from the bus pins during the cycle that follows the request.

Top module: `extbus_decoder`

## Requirements
- R1: While reset is high and after it is released, the block's idle state holds until the first cycle: `oe_n`=1, `ce_n`=1, `bus_drv_en`=0, `io_sel`=0, `ram_sel`=0, `ext_addr`=0 and `cpu_rdata`=0.
- R2: `ext_addr` equals the `cpu_addr` that was present at the previous rising edge, on every cycle, whatever `cyc_valid` and `cyc_rd` are.
- R3: For a valid read (`cyc_valid`=1, `cyc_rd`=1) at an address in 0x020..0x09F or 0x100..0x1FFF, `oe_n` is 0 in the following cycle. For every other address it is 1.
- R4: Addresses 0x08, 0x09, 0x0D, 0x0E, 0x0F, 0x10, 0x11, 0x1C, 0x1D and 0x1F are holes. A valid read or write at a hole leaves, one cycle later, `oe_n`=1, `ce_n`=1, `bus_drv_en`=0, `io_sel`=0 and `cpu_rdata`=0.
- R5: A valid read of a used I/O address (0x00..0x1F that is not a hole) or of RAM (0x0A0..0x0FF) gives, one cycle later, `bus_drv_en`=1, and `bus_dout` equal to the `int_rdata` sampled with the request.
- R6: `ce_n` is 0 in exactly the cycles where `oe_n` is 0, that is, only after a valid external read.
- R7: A write (`cyc_rd`=0) or an idle cycle (`cyc_valid`=0) gives, one cycle later, `oe_n`=1, `ce_n`=1 and `bus_drv_en`=0.
- R8: In the cycle after a valid external read, `cpu_rdata` follows `bus_din` combinationally. After a valid internal read it equals the captured `int_rdata`. Otherwise it is 0.
- R9: One cycle after a valid cycle (read or write), `io_sel` is 1 when the address was a used I/O address and `ram_sel` is 1 when it was in 0x0A0..0x0FF. Both are 0 otherwise.
- R10: `oe_n`=0 and `bus_drv_en`=1 never occur together, so the block and the EPROM never drive the data bus at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal processor clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_valid | input | 1 | A bus cycle is present this clock |
| cyc_rd | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 13 | CPU address |
| int_rdata | input | 8 | Read data from internal I/O and RAM |
| bus_din | input | 8 | Data sampled from the external data pins |
| ext_addr | output | 13 | External address lines |
| oe_n | output | 1 | External memory output enable, active low |
| ce_n | output | 1 | Direction status, 0 = data flows in from external memory |
| bus_drv_en | output | 1 | Enable for the external data bus drivers |
| bus_dout | output | 8 | Data driven onto the external bus |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| io_sel | output | 1 | Registered select for used I/O registers |
| ram_sel | output | 1 | Registered select for internal RAM |

## Verification
The bench presents each cycle's inputs on a falling edge. It checks the registered results on the next falling edge, exactly one rising edge later. Those results are `ext_addr`, `oe_n`, `ce_n`, `bus_drv_en`, `bus_dout`, `io_sel` and `ram_sel`. `cpu_rdata` is checked on that same falling edge. Because its source for external reads is `bus_din` through a mux, the bench holds `bus_din` steady until the sample is taken. The expected values come from a bench-side map function fed with the inputs of the previous cycle. Directed cycles cover every hole, each region boundary, writes and idle cycles. Seeded random cycles cover the rest.

// File: rtl/ebd_pkg.sv
package ebd_pkg;

  // Classification of a CPU address in the emulator memory map
  typedef enum logic [1:0] {
    RGN_IO   = 2'd0,  // used I/O register
    RGN_HOLE = 2'd1,  // unused I/O location
    RGN_EXT  = 2'd2,  // external memory
    RGN_RAM  = 2'd3   // internal RAM (stack included)
  } region_t;

endpackage

// File: rtl/ebd_region_classify.sv
module ebd_region_classify
  import ebd_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int PAGE_W   = 8,
  parameter int IO_SIZE  = 32,
  parameter int RAM_BASE = 160,
  parameter logic [IO_SIZE-1:0] HOLE_MASK = 32'hB003_E300
) (
  input  logic [ADDR_W-1:0] addr,
  output region_t           region
);

  localparam int IO_W = $clog2(IO_SIZE);
  localparam logic [PAGE_W-1:0] IO_END  = PAGE_W'(IO_SIZE);
  localparam logic [PAGE_W-1:0] RAM_LO  = PAGE_W'(RAM_BASE);

  logic              page_zero;
  logic [PAGE_W-1:0] low_byte;
  logic              is_hole;

  assign page_zero = (addr[ADDR_W-1:PAGE_W] == '0);
  assign low_byte  = addr[PAGE_W-1:0];
  assign is_hole   = HOLE_MASK[addr[IO_W-1:0]];

  always_comb begin
    if (!page_zero)              region = RGN_EXT;
    else if (low_byte < IO_END)  region = is_hole ? RGN_HOLE : RGN_IO;
    else if (low_byte < RAM_LO)  region = RGN_EXT;
    else                         region = RGN_RAM;
  end

endmodule

// File: rtl/ebd_rdata_mux.sv
module ebd_rdata_mux #(
  parameter int DATA_W = 8
) (
  input  logic              ext_rd,
  input  logic              int_rd,
  input  logic [DATA_W-1:0] bus_din,
  input  logic [DATA_W-1:0] int_q,
  output logic [DATA_W-1:0] cpu_rdata
);

  always_comb begin
    if (ext_rd)      cpu_rdata = bus_din;
    else if (int_rd) cpu_rdata = int_q;
    else             cpu_rdata = '0;
  end

endmodule

// File: rtl/extbus_decoder.sv
module extbus_decoder
  import ebd_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int IO_SIZE  = 32,
  parameter int RAM_BASE = 160,
  parameter logic [IO_SIZE-1:0] HOLE_MASK = 32'hB003_E300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic              cyc_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] int_rdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              oe_n,
  output logic              ce_n,
  output logic              bus_drv_en,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              io_sel,
  output logic              ram_sel
);

  region_t region;
  logic    rd_now, ext_rd_now, int_rd_now;
  logic    ext_rd_q, int_rd_q;

  ebd_region_classify #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (8),
    .IO_SIZE  (IO_SIZE),
    .RAM_BASE (RAM_BASE),
    .HOLE_MASK(HOLE_MASK)
  ) u_classify (
    .addr  (cpu_addr),
    .region(region)
  );

  assign rd_now     = cyc_valid & cyc_rd;
  assign ext_rd_now = rd_now & (region == RGN_EXT);
  assign int_rd_now = rd_now & ((region == RGN_IO) | (region == RGN_RAM));

  // Registered control: one update per clock, no glitches within a cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_addr   <= '0;
      oe_n       <= 1'b1;
      ce_n       <= 1'b1;
      bus_drv_en <= 1'b0;
      bus_dout   <= '0;
      ext_rd_q   <= 1'b0;
      int_rd_q   <= 1'b0;
      io_sel     <= 1'b0;
      ram_sel    <= 1'b0;
    end else begin
      ext_addr   <= cpu_addr;
      oe_n       <= ~ext_rd_now;
      ce_n       <= ~ext_rd_now;
      bus_drv_en <= int_rd_now;
      ext_rd_q   <= ext_rd_now;
      int_rd_q   <= int_rd_now;
      io_sel     <= cyc_valid & (region == RGN_IO);
      ram_sel    <= cyc_valid & (region == RGN_RAM);
      if (int_rd_now) bus_dout <= int_rdata;
    end
  end

  ebd_rdata_mux #(.DATA_W(DATA_W)) u_rdata_mux (
    .ext_rd   (ext_rd_q),
    .int_rd   (int_rd_q),
    .bus_din  (bus_din),
    .int_q    (bus_dout),
    .cpu_rdata(cpu_rdata)
  );

  AST_ADDR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ext_addr == $past(cpu_addr)); // R2

  AST_HOLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && region == RGN_HOLE) |=> (oe_n && ce_n && !bus_drv_en && !io_sel && cpu_rdata == '0)); // R4

  AST_INT_ECHO: assert property (@(posedge clk) disable iff (rst)
    int_rd_now |=> (bus_drv_en && bus_dout == $past(int_rdata))); // R5

  AST_CE_WITH_OE: assert property (@(posedge clk) disable iff (rst)
    ce_n == oe_n); // R6

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cyc_valid || !cyc_rd) |=> (oe_n && ce_n && !bus_drv_en)); // R7

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && bus_drv_en)); // R10

endmodule

// File: tb/extbus_decoder_tb.sv
`timescale 1ns/1ps
module extbus_decoder_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cyc_valid, cyc_rd;
  logic [12:0] cpu_addr;
  logic [7:0]  int_rdata, bus_din;
  logic [12:0] ext_addr;
  logic        oe_n, ce_n, bus_drv_en, io_sel, ram_sel;
  logic [7:0]  bus_dout, cpu_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  extbus_decoder u_dut (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_rd(cyc_rd),
    .cpu_addr(cpu_addr), .int_rdata(int_rdata), .bus_din(bus_din),
    .ext_addr(ext_addr), .oe_n(oe_n), .ce_n(ce_n), .bus_drv_en(bus_drv_en),
    .bus_dout(bus_dout), .cpu_rdata(cpu_rdata), .io_sel(io_sel), .ram_sel(ram_sel)
  );

  // 0 = used I/O, 1 = hole, 2 = external, 3 = RAM
  function automatic int map_of(input logic [12:0] a);
    if (a >= 13'h100) return 2;
    if (a < 13'h020) begin
      case (a[4:0])
        5'h08, 5'h09, 5'h0D, 5'h0E, 5'h0F, 5'h10, 5'h11, 5'h1C, 5'h1D, 5'h1F: return 1;
        default: return 0;
      endcase
    end
    if (a < 13'h0A0) return 2;
    return 3;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic step(input bit v, input bit rd, input logic [12:0] a,
                      input logic [7:0] idat, input logic [7:0] bdat);
    int  m;
    bit  ext, intr;
    int  exp_rd;
    cyc_valid = v; cyc_rd = rd; cpu_addr = a; int_rdata = idat; bus_din = bdat;
    @(negedge clk);
    m    = map_of(a);
    ext  = v && rd && (m == 2);
    intr = v && rd && (m == 0 || m == 3);
    exp_rd = ext ? int'(bdat) : (intr ? int'(idat) : 0);
    chk(ext_addr == a, "R2", "ext_addr", ext_addr, a);
    chk(oe_n == !ext, "R3", "oe_n", oe_n, !ext);
    chk(ce_n == !ext, "R6", "ce_n", ce_n, !ext);
    chk(bus_drv_en == intr, "R5", "bus_drv_en", bus_drv_en, intr);
    if (intr) chk(bus_dout == idat, "R5", "bus_dout", bus_dout, idat);
    chk(cpu_rdata == exp_rd, (m == 1) ? "R4" : "R8", "cpu_rdata", cpu_rdata, exp_rd);
    chk(io_sel == (v && m == 0), (m == 1) ? "R4" : "R9", "io_sel", io_sel, v && m == 0);
    chk(ram_sel == (v && m == 3), "R9", "ram_sel", ram_sel, v && m == 3);
    if (!(v && rd)) chk(oe_n && ce_n && !bus_drv_en, "R7", "quiet", {oe_n, ce_n, bus_drv_en}, 3'b110);
    chk(!(!oe_n && bus_drv_en), "R10", "contention", {oe_n, bus_drv_en}, 0);
  endtask

  initial begin
    #150000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [12:0] holes [10];
    logic [12:0] edges [9];
    holes = '{13'h08, 13'h09, 13'h0D, 13'h0E, 13'h0F, 13'h10, 13'h11, 13'h1C, 13'h1D, 13'h1F};
    edges = '{13'h000, 13'h01E, 13'h020, 13'h09F, 13'h0A0, 13'h0C0, 13'h0FF, 13'h100, 13'h1FFF};
    void'($urandom(32'd2024));
    rst = 1'b1; cyc_valid = 0; cyc_rd = 0; cpu_addr = 13'h1234; int_rdata = 8'h5A; bus_din = 8'hA5;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(oe_n && ce_n && !bus_drv_en && !io_sel && !ram_sel && ext_addr == 0 && cpu_rdata == 0,
        "R1", "reset", {oe_n, ce_n, bus_drv_en, io_sel, ram_sel}, 5'b11000);
    rst = 1'b0;
    // holes: reads and writes (R4)
    foreach (holes[i]) begin
      step(1, 1, holes[i], 8'hC3, 8'h3C);
      step(1, 0, holes[i], 8'hC3, 8'h3C);
    end
    // region edges: read, write, idle (R3, R5, R7, R8, R9)
    foreach (edges[i]) begin
      step(1, 1, edges[i], 8'h11 + 8'(i), 8'hE0 + 8'(i));
      step(1, 0, edges[i], 8'h22, 8'h33);
      step(0, 1, edges[i], 8'h44, 8'h55);
    end
    // back-to-back external then internal reads
    step(1, 1, 13'h1FF0, 8'h01, 8'hBE);
    step(1, 1, 13'h0A5, 8'h77, 8'hBE);
    step(1, 1, 13'h050, 8'h77, 8'h99);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [12:0] a;
      a = ($urandom % 2) ? 13'($urandom % 256) : 13'($urandom);
      step(($urandom % 8) != 0, ($urandom % 4) != 0, a, 8'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule